// File: doc/BRIEF.md
# Calendar Alarm Match Interrupt

This block holds a set of alarm registers and compares them against the current time supplied by an external clock/calendar counter. It checks seconds, minutes, hours and one shared day register. The day register is read either as a multi-day weekday mask or as a BCD day of the month, as chosen by a select bit. Each field can be left out of the comparison.

The comparison takes place only when the once-per-second strobe is high. When every field that is still enabled agrees with the current time, the block sets a sticky alarm flag. If the alarm interrupt enable is also set, the flag pulls an active-low interrupt line low. Software clears the flag by writing 0 to it. Clearing the interrupt enable only releases the line and leaves the flag set.

Top module: `cal_alarm_match`

## Requirements
- R1: A write at address 0 (seconds), 1 (minutes), 2 (hours), 3 (day) or 4 (control) stores the 8-bit data. `rd_data` returns the register at `reg_addr` one clock later. Addresses 5 to 7 read as 0. Control bit 0 is the day-mode select and control bit 1 is the interrupt enable. Control bit 2 reads back the alarm flag.
- R2: When `tick_sec` is 0, the flag is never set, even if all fields match.
- R3: When bit 7 of a seconds, minutes or hours alarm register is 0, that field matches only if the register's bits 6:0 equal the 7-bit BCD current value. If any enabled field differs, the flag is not set on the strobe.
- R4: When bit 7 of any alarm register is 1, that field is excluded from the comparison and counts as a match.
- R5: When day-mode select is 0, day register bits 6:0 form a weekday mask, with bit 0 for Sunday through bit 6 for Saturday. The field matches if any set mask bit coincides with the one-hot `cur_wday`.
- R6: When day-mode select is 1, the day field matches if day register bits 6:0 equal the 7-bit BCD `cur_date`.
- R7: A strobe with a full match sets the flag on that clock edge. The flag then stays at 1 until software clears it.
- R8: Writing control with bit 2 equal to 0 clears the flag. Writing 1 to bit 2 has no effect. A match in the same cycle as a clear leaves the flag at 1.
- R9: `irq_n` is 0 in the cycle after flag and interrupt enable are both 1, and 1 otherwise. Clearing the enable releases `irq_n` but leaves the flag set.
- R10: After reset, all registers read 0, the flag is 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_sec | input | 1 | Once-per-second evaluation strobe |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours, BCD |
| cur_date | input | 7 | Current day of month, BCD |
| cur_wday | input | 7 | Current weekday, one-hot, bit 0 is Sunday |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| rd_data | output | 8 | Registered read data for `reg_addr` |
| irq_n | output | 1 | 0 drives the interrupt line low, 1 releases it |

## Verification
The checker verifies on every cycle the relation between flag and interrupt line, that the flag cannot rise without a strobe, that it stays sticky unless a clear is written, and that a strobed full match always sets it. Only the bench scenarios show the following:
- the per-field comparisons
- the effect of the disable bits
- the multi-day weekday mask and the date mode
- the precedence of a match over a simultaneous clear

The bench's reference model covers these on every clock, and its named checks cover them at the chosen points.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int unsigned FIELD_W   = 8;
  localparam int unsigned CMP_W     = FIELD_W - 1;
  localparam int unsigned DAYS      = 7;
  localparam int unsigned NUM_TIME  = 3;
  localparam int unsigned ADDR_W    = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_SEC  = 3'd0,
    A_MIN  = 3'd1,
    A_HOUR = 3'd2,
    A_DAY  = 3'd3,
    A_CTRL = 3'd4
  } reg_sel_e;

  localparam int unsigned CTRL_SEL_BIT  = 0;
  localparam int unsigned CTRL_EN_BIT   = 1;
  localparam int unsigned CTRL_FLAG_BIT = 2;
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
#(
  parameter int unsigned W  = FIELD_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NT = NUM_TIME
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [W-1:0]         wdata,
  input  logic                 flag_i,
  output logic [NT-1:0][W-1:0] time_alm,
  output logic [W-1:0]         day_alm,
  output logic                 day_sel,
  output logic                 irq_en,
  output logic                 flag_clr,
  output logic [W-1:0]         rdata
);
  logic [W-1:0] rd_mux;

  for (genvar g = 0; g < NT; g++) begin : g_time
    always_ff @(posedge clk) begin
      if (rst)
        time_alm[g] <= '0;
      else if (we && addr == AW'(g))
        time_alm[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      day_alm <= '0;
      day_sel <= 1'b0;
      irq_en  <= 1'b0;
    end else if (we) begin
      if (addr == A_DAY) day_alm <= wdata;
      if (addr == A_CTRL) begin
        day_sel <= wdata[CTRL_SEL_BIT];
        irq_en  <= wdata[CTRL_EN_BIT];
      end
    end
  end

  assign flag_clr = we && (addr == A_CTRL) && !wdata[CTRL_FLAG_BIT];

  always_comb begin
    rd_mux = '0;
    if (addr < AW'(NT))
      rd_mux = time_alm[addr[$clog2(NT)-1:0]];
    else if (addr == A_DAY)
      rd_mux = day_alm;
    else if (addr == A_CTRL) begin
      rd_mux[CTRL_SEL_BIT]  = day_sel;
      rd_mux[CTRL_EN_BIT]   = irq_en;
      rd_mux[CTRL_FLAG_BIT] = flag_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
#(
  parameter int unsigned W  = FIELD_W,
  parameter int unsigned NT = NUM_TIME,
  parameter int unsigned ND = DAYS
) (
  input  logic [NT-1:0][W-1:0] time_alm,
  input  logic [NT-1:0][W-2:0] time_cur,
  input  logic [W-1:0]         day_alm,
  input  logic [ND-1:0]        wday,
  input  logic [W-2:0]         date,
  input  logic                 day_sel,
  output logic                 match_all
);
  logic [NT-1:0] hit;
  logic          day_hit;

  for (genvar g = 0; g < NT; g++) begin : g_cmp
    assign hit[g] = time_alm[g][W-1] || (time_alm[g][W-2:0] == time_cur[g]);
  end

  always_comb begin
    if (day_alm[W-1])
      day_hit = 1'b1;
    else if (day_sel)
      day_hit = (day_alm[W-2:0] == date);
    else
      day_hit = |(day_alm[ND-1:0] & wday);
  end

  assign match_all = (&hit) && day_hit;
endmodule

// File: rtl/cal_alarm_irq.sv
module cal_alarm_irq (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic match,
  input  logic clr,
  input  logic en,
  output logic flag,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (rst)                flag <= 1'b0;
    else if (tick && match) flag <= 1'b1;
    else if (clr)           flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= !(flag && en);
  end
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
#(
  parameter int unsigned W  = FIELD_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_sec,
  input  logic [W-2:0]  cur_sec,
  input  logic [W-2:0]  cur_min,
  input  logic [W-2:0]  cur_hour,
  input  logic [W-2:0]  cur_date,
  input  logic [DAYS-1:0] cur_wday,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  rd_data,
  output logic          irq_n
);
  localparam int unsigned NT = NUM_TIME;

  logic [NT-1:0][W-1:0] time_alm;
  logic [NT-1:0][W-2:0] time_cur;
  logic [W-1:0]         day_alm;
  logic                 day_sel, irq_en, flag_clr, flag_q, match_all;

  assign time_cur = {cur_hour, cur_min, cur_sec};

  cal_alarm_regs #(.W(W), .AW(AW), .NT(NT)) i_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .flag_i(flag_q), .time_alm(time_alm), .day_alm(day_alm),
    .day_sel(day_sel), .irq_en(irq_en), .flag_clr(flag_clr), .rdata(rd_data)
  );

  cal_alarm_cmp #(.W(W), .NT(NT), .ND(DAYS)) i_cmp (
    .time_alm(time_alm), .time_cur(time_cur), .day_alm(day_alm),
    .wday(cur_wday), .date(cur_date), .day_sel(day_sel), .match_all(match_all)
  );

  cal_alarm_irq i_irq (
    .clk(clk), .rst(rst), .tick(tick_sec), .match(match_all), .clr(flag_clr),
    .en(irq_en), .flag(flag_q), .irq_n(irq_n)
  );
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk (
  input logic clk,
  input logic rst,
  input logic tick_sec,
  input logic match_all,
  input logic flag,
  input logic irq_en,
  input logic flag_clr,
  input logic irq_n
);
  // R2
  no_tick_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_sec && !flag) |=> !flag);
  // R7
  strobe_match_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_sec && match_all) |=> flag);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);
  // R9
  irq_low_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && irq_en) |=> !irq_n);
  // R9
  irq_release_chk: assert property (@(posedge clk) disable iff (rst)
    !(flag && irq_en) |=> irq_n);
  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (irq_n && !flag));
endmodule

bind cal_alarm_match cal_alarm_chk i_chk (
  .clk(clk), .rst(rst), .tick_sec(tick_sec), .match_all(match_all),
  .flag(flag_q), .irq_en(irq_en), .flag_clr(flag_clr), .irq_n(irq_n)
);

// File: tb/test_cal_alarm_match.sv
module test_cal_alarm_match;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_sec = 1'b0;
  logic [6:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0, cur_wday = '0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] rd_data;
  logic       irq_n;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cal_alarm_match i_cal_alarm_match (
    .clk(clk), .rst(rst), .tick_sec(tick_sec), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_date(cur_date), .cur_wday(cur_wday), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_data(rd_data), .irq_n(irq_n)
  );

  // behavioural reference model
  logic [7:0] m_reg [0:3];
  logic       m_sel, m_en, m_flag, m_irqn;
  logic [7:0] m_rd;

  function automatic bit fld_ok(input logic [7:0] r, input logic [6:0] c);
    return r[7] ? 1'b1 : (r[6:0] == c);
  endfunction

  always @(posedge clk) begin
    bit m_match;
    logic [7:0] rv;
    if (rst) begin
      for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
      m_sel = 0; m_en = 0; m_flag = 0; m_irqn = 1; m_rd = 8'h00;
    end else begin
      m_irqn = !(m_flag && m_en);
      case (reg_addr)
        3'd0, 3'd1, 3'd2, 3'd3: rv = m_reg[reg_addr];
        3'd4: rv = {5'b0, m_flag, m_en, m_sel};
        default: rv = 8'h00;
      endcase
      m_rd = rv;
      m_match = fld_ok(m_reg[0], cur_sec) && fld_ok(m_reg[1], cur_min) &&
                fld_ok(m_reg[2], cur_hour);
      if (!m_reg[3][7]) begin
        if (m_sel) m_match = m_match && (m_reg[3][6:0] == cur_date);
        else       m_match = m_match && ((m_reg[3][6:0] & cur_wday) != 0);
      end
      if (tick_sec && m_match) m_flag = 1;
      else if (reg_we && reg_addr == 3'd4 && !reg_wdata[2]) m_flag = 0;
      if (reg_we) begin
        if (reg_addr < 3'd4) m_reg[reg_addr] = reg_wdata;
        else if (reg_addr == 3'd4) begin m_sel = reg_wdata[0]; m_en = reg_wdata[1]; end
      end
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      n_cmp++;
      if (irq_n !== m_irqn) begin
        n_bad++;
        $display("FAIL R9 model irq_n actual=%b expected=%b t=%0t", irq_n, m_irqn, $time);
      end
      n_cmp++;
      if (rd_data !== m_rd) begin
        n_bad++;
        $display("FAIL R1 model rd_data actual=%h expected=%h t=%0t", rd_data, m_rd, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic tick;
    @(negedge clk); tick_sec = 1;
    @(negedge clk); tick_sec = 0;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [6:0] h, input logic [6:0] m, input logic [6:0] s,
                          input logic [6:0] wd, input logic [6:0] dt);
    @(negedge clk); cur_hour = h; cur_min = m; cur_sec = s; cur_wday = wd; cur_date = dt;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    rd(3'd4, v); chk("R10 ctrl after reset", v, 8'h00);
    rd(3'd0, v); chk("R10 sec alarm after reset", v, 8'h00);
    chk("R10 irq_n after reset", {7'b0, irq_n}, 8'h01);
    // R1 programming and readback
    wr(3'd0, 8'h30); wr(3'd1, 8'h15); wr(3'd2, 8'h12); wr(3'd3, 8'h04);
    wr(3'd4, 8'h02);
    rd(3'd1, v); chk("R1 min readback", v, 8'h15);
    rd(3'd3, v); chk("R1 day readback", v, 8'h04);
    rd(3'd6, v); chk("R1 unused addr reads 0", v, 8'h00);
    // R2 match present but no strobe
    set_time(7'h12, 7'h15, 7'h30, 7'h04, 7'h10);
    repeat (5) @(negedge clk);
    rd(3'd4, v); chk("R2 no flag without strobe", v, 8'h02);
    // R7 strobe with full match, R9 irq low
    tick();
    chk("R9 irq low after match", {7'b0, irq_n}, 8'h00);
    rd(3'd4, v); chk("R7 flag set", v, 8'h06);
    // R8 writing 1 to flag has no effect
    wr(3'd4, 8'h06);
    rd(3'd4, v); chk("R8 write-1 ignored", v, 8'h06);
    // R9 disable releases line, flag stays
    wr(3'd4, 8'h04);
    @(negedge clk);
    chk("R9 irq released", {7'b0, irq_n}, 8'h01);
    rd(3'd4, v); chk("R9 flag kept when enable cleared", v, 8'h04);
    // R8 clear
    wr(3'd4, 8'h02);
    rd(3'd4, v); chk("R8 flag cleared", v, 8'h02);
    // R3 minute mismatch
    set_time(7'h12, 7'h16, 7'h30, 7'h04, 7'h10);
    tick();
    rd(3'd4, v); chk("R3 mismatch no flag", v, 8'h02);
    // R4 disabled minute field counts as match
    wr(3'd1, 8'h95);
    tick();
    rd(3'd4, v); chk("R4 disabled field matches", v, 8'h06);
    wr(3'd4, 8'h02);
    // R5 weekday mask Sunday+Saturday
    wr(3'd3, 8'h41);
    set_time(7'h12, 7'h16, 7'h30, 7'h02, 7'h10);
    tick();
    rd(3'd4, v); chk("R5 Monday not in mask", v, 8'h02);
    set_time(7'h12, 7'h16, 7'h30, 7'h40, 7'h10);
    tick();
    rd(3'd4, v); chk("R5 Saturday in mask", v, 8'h06);
    // R6 date mode
    wr(3'd3, 8'h25);
    wr(3'd4, 8'h03);
    set_time(7'h12, 7'h16, 7'h30, 7'h40, 7'h24);
    tick();
    rd(3'd4, v); chk("R6 date mismatch", v, 8'h03);
    set_time(7'h12, 7'h16, 7'h30, 7'h00, 7'h25);
    tick();
    rd(3'd4, v); chk("R6 date match", v, 8'h07);
    // R8 clear and match in same cycle: match wins
    @(negedge clk); reg_we = 1; reg_addr = 3'd4; reg_wdata = 8'h03; tick_sec = 1;
    @(negedge clk); reg_we = 0; tick_sec = 0;
    rd(3'd4, v); chk("R8 match beats clear", v, 8'h07);
    // R3 seconds mismatch after clear
    wr(3'd4, 8'h03);
    set_time(7'h12, 7'h16, 7'h31, 7'h00, 7'h25);
    tick();
    rd(3'd4, v); chk("R3 seconds mismatch", v, 8'h03);
    chk("R9 irq idle", {7'b0, irq_n}, 8'h01);
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule